// File: doc/BRIEF.md
# Signed Cyclic Word Rotator

This block rotates a vector of message words by a signed amount in a single pass. The vector length is a design parameter. It need not be a power of two, so a 61-word vector is as natural a fit as a 64-word one. A positive shift rotates the vector down: each output position takes the word that sits that many places further along the input, wrapping at the vector length. A negative shift rotates the vector up by its magnitude.

Internally the signed amount is first reduced to a down-rotation count in the range 0 to length−1. An up rotation by u becomes a down rotation by length−u. That count then steers a chain of conditional rotation stages. The stage for bit b moves every word by 2^b places, modulo the vector length. No rotation pattern is stored anywhere; the binary count alone selects the stages.

A new vector and shift may be presented on every clock. With the optional output register enabled, which is the default, the result appears one cycle later with a matching valid flag. Word i of a vector occupies bits [i*WORD_W +: WORD_W].

Top module: `msg_rotator`

## Requirements
- R1: For a shift s with 0 <= s < P_LEN, output word i equals input word (i+s) mod P_LEN, for every i.
- R2: For a negative shift −u with 0 < u < P_LEN, output word i equals input word (i−u) mod P_LEN, which is the same as a down rotation by P_LEN−u.
- R3: A shift whose magnitude is P_LEN or more acts as its value reduced modulo P_LEN. Shifts of +P_LEN and −P_LEN leave the vector unchanged, P_LEN+3 behaves like 3, and the extreme codes of the signed shift input follow the same rule.
- R4: A shift of zero passes the vector through unchanged.
- R5: Wraparound happens at P_LEN and not at the next power of two. With P_LEN=61 and a shift of 60, output word 0 is input word 60 and output word 1 is input word 0.
- R6: One vector is accepted per clock with no gaps required. With REGISTERED=1, out_valid and out_vec follow in_valid and in_vec by exactly one clock, and out_valid is low one cycle after in_valid was low.
- R7: While rst_n is low, out_valid and out_vec are zero.
- R8: Every bit of each WORD_W-bit word is carried intact through the rotation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset for the output register |
| in_valid | input | 1 | Input vector and shift are valid this cycle |
| in_vec | input | P_LEN*WORD_W | Input words, word i at bits [i*WORD_W +: WORD_W] |
| shift_amt | input | SHIFT_W | Signed two's complement shift; positive rotates down, negative rotates up |
| out_valid | output | 1 | Rotated vector is valid |
| out_vec | output | P_LEN*WORD_W | Rotated words, same layout as in_vec |

## Verification
The bench sweeps every down shift and every up shift across the full length, so each stage combination and each wrap point is exercised. A design that wrapped at 64 instead of 61 would deliver garbage words near the end of the vector for large shifts. A sign-handling error would show up as up shifts mirrored into down shifts.

Shifts of magnitude P_LEN and beyond, including the most negative input code, target the modulo reduction. A design that only decomposed the raw bits would rotate +61 by 61 positions of a 64-wide structure instead of leaving the vector untouched.

Back-to-back vectors interleaved with idle cycles catch a wrong latency or a valid flag that lingers. Patterns of all-ones and alternating bits reveal dropped or swapped word bits.

// File: rtl/rot_pkg.sv
package rot_pkg;

  // Reduce a signed rotation to a down-rotation count in [0, len).
  // An up rotation by u maps to a down rotation by len - u.
  function automatic int unsigned down_amount(input int signed s, input int unsigned len);
    int unsigned mag;
    int unsigned rem;
    mag = (s < 0) ? int'(-s) : int'(s);
    rem = mag % len;
    if (s < 0 && rem != 0) return len - rem;
    return rem;
  endfunction

endpackage

// File: rtl/rot_shift_norm.sv
module rot_shift_norm #(
  parameter int P_LEN   = 61,
  parameter int SHIFT_W = 8
) (
  input  logic signed [SHIFT_W-1:0]         shift_amt,
  output logic        [$clog2(P_LEN)-1:0]   dn_amt
);
  localparam int AMT_W = $clog2(P_LEN);

  int signed shift_int;
  assign shift_int = int'(shift_amt);
  assign dn_amt    = AMT_W'(rot_pkg::down_amount(shift_int, P_LEN));

endmodule

// File: rtl/rot_stage.sv
module rot_stage #(
  parameter int P_LEN  = 61,
  parameter int WORD_W = 6,
  parameter int DIST   = 1
) (
  input  logic                      en,
  input  logic [P_LEN*WORD_W-1:0]   in_vec,
  output logic [P_LEN*WORD_W-1:0]   out_vec
);
  localparam int DIST_MOD = DIST % P_LEN;

  generate
    for (genvar i = 0; i < P_LEN; i++) begin : g_word
      localparam int SRC = (i + DIST_MOD) % P_LEN;
      assign out_vec[i*WORD_W +: WORD_W] = en ? in_vec[SRC*WORD_W +: WORD_W]
                                              : in_vec[i*WORD_W +: WORD_W];
    end
  endgenerate

endmodule

// File: rtl/msg_rotator.sv
module msg_rotator #(
  parameter int P_LEN      = 61,
  parameter int WORD_W     = 6,
  parameter int SHIFT_W    = 8,
  parameter bit REGISTERED = 1'b1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  input  logic [P_LEN*WORD_W-1:0]     in_vec,
  input  logic signed [SHIFT_W-1:0]   shift_amt,
  output logic                        out_valid,
  output logic [P_LEN*WORD_W-1:0]     out_vec
);
  localparam int NSTG  = $clog2(P_LEN);
  localparam int VEC_W = P_LEN * WORD_W;

  // Normalized down-rotation count
  logic [NSTG-1:0] dn_amt;

  rot_shift_norm #(.P_LEN(P_LEN), .SHIFT_W(SHIFT_W)) u_norm (
    .shift_amt (shift_amt),
    .dn_amt    (dn_amt)
  );

  // Stage chain: stage b rotates down by 2^b when dn_amt[b] is set
  logic [VEC_W-1:0] chain [NSTG+1];
  assign chain[0] = in_vec;

  generate
    for (genvar b = 0; b < NSTG; b++) begin : g_stage
      rot_stage #(.P_LEN(P_LEN), .WORD_W(WORD_W), .DIST(1 << b)) u_stg (
        .en      (dn_amt[b]),
        .in_vec  (chain[b]),
        .out_vec (chain[b+1])
      );
    end
  endgenerate

  logic [VEC_W-1:0] rot_result;
  assign rot_result = chain[NSTG];

  // Named observation points for the assertions
  int signed   shift_int;
  int          src_first;
  int          src_last;
  logic [WORD_W-1:0] src_word_first;
  logic [WORD_W-1:0] src_word_last;
  logic        full_turn;
  logic        zero_shift;

  always_comb begin
    shift_int      = int'(shift_amt);
    src_first      = ((shift_int % P_LEN) + P_LEN) % P_LEN;
    src_last       = (((P_LEN - 1) + (shift_int % P_LEN)) + P_LEN) % P_LEN;
    src_word_first = in_vec[src_first*WORD_W +: WORD_W];
    src_word_last  = in_vec[src_last*WORD_W +: WORD_W];
    full_turn      = (shift_int == P_LEN) || (shift_int == -P_LEN);
    zero_shift     = (shift_int == 0);
  end

  generate
    if (REGISTERED) begin : g_reg
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          out_valid <= 1'b0;
          out_vec   <= '0;
        end else begin
          out_valid <= in_valid;
          out_vec   <= rot_result;
        end
      end

      AST_AMT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> (int'(dn_amt) < P_LEN)); // R3

      AST_LATENCY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (out_valid == $past(in_valid))); // R6

      AST_FIRST_WORD_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_vec[WORD_W-1:0] == $past(src_word_first))); // R1

      AST_LAST_WORD_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_vec[VEC_W-1 -: WORD_W] == $past(src_word_last))); // R5

      AST_ZERO_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && zero_shift) |=> (out_vec == $past(in_vec))); // R4

      AST_FULL_TURN: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && full_turn) |=> (out_vec == $past(in_vec))); // R3
    end else begin : g_comb
      assign out_valid = in_valid;
      assign out_vec   = rot_result;
    end
  endgenerate

endmodule

// File: tb/sim_msg_rotator.sv
module sim_msg_rotator;
  localparam int CLK_PERIOD = 10;
  localparam int P_LEN   = 61;
  localparam int WORD_W  = 6;
  localparam int SHIFT_W = 8;
  localparam int VEC_W   = P_LEN * WORD_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [VEC_W-1:0] in_vec = '0;
  logic signed [SHIFT_W-1:0] shift_amt = '0;
  logic out_valid;
  logic [VEC_W-1:0] out_vec;

  int checks = 0;
  int failures = 0;
  logic iv_q = 1'b0;
  logic done = 1'b0;

  logic [VEC_W-1:0] exp_q [$];
  string            tag_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  msg_rotator #(.P_LEN(P_LEN), .WORD_W(WORD_W), .SHIFT_W(SHIFT_W), .REGISTERED(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_vec(in_vec),
    .shift_amt(shift_amt), .out_valid(out_valid), .out_vec(out_vec)
  );

  // Reference model: output word i comes from input index i+s, folded into [0, P_LEN)
  function automatic logic [VEC_W-1:0] model(input logic [VEC_W-1:0] v, input int s);
    logic [VEC_W-1:0] r;
    r = '0;
    for (int i = 0; i < P_LEN; i++) begin
      int idx;
      idx = i + s;
      while (idx < 0) idx += P_LEN;
      idx = idx % P_LEN;
      r[i*WORD_W +: WORD_W] = v[idx*WORD_W +: WORD_W];
    end
    return r;
  endfunction

  function automatic logic [VEC_W-1:0] ramp_vec();
    logic [VEC_W-1:0] v;
    for (int i = 0; i < P_LEN; i++) v[i*WORD_W +: WORD_W] = WORD_W'(i);
    return v;
  endfunction

  function automatic logic [VEC_W-1:0] rand_vec();
    logic [VEC_W-1:0] v;
    for (int i = 0; i < P_LEN; i++) v[i*WORD_W +: WORD_W] = WORD_W'($urandom);
    return v;
  endfunction

  function automatic logic [VEC_W-1:0] bits_vec();
    logic [VEC_W-1:0] v;
    for (int i = 0; i < P_LEN; i++)
      v[i*WORD_W +: WORD_W] = (i % 3 == 0) ? '1 : ((i % 3 == 1) ? 6'h2A : 6'h15);
    return v;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [VEC_W-1:0] act, input logic [VEC_W-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Driver: presents one vector and queues its expected result
  task automatic send(input logic [VEC_W-1:0] v, input int s, input string tag);
    @(negedge clk);
    in_valid  = 1'b1;
    in_vec    = v;
    shift_amt = SHIFT_W'(s);
    exp_q.push_back(model(v, s));
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_vec   = rand_vec();
    end
  endtask

  always @(posedge clk) iv_q <= rst_n ? in_valid : 1'b0;

  // Monitor: compares each produced vector against the scoreboard
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(out_valid == iv_q, "R6", "valid latency",
            VEC_W'(out_valid), VEC_W'(iv_q));
      if (out_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R6", "unexpected output", out_vec, '0);
        end else begin
          logic [VEC_W-1:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(out_vec == e, t, "rotated vector", out_vec, e);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 50000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [VEC_W-1:0] rv;
    // R7: reset state
    in_vec = ramp_vec();
    in_valid = 1'b1;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R7", "out_valid in reset", VEC_W'(out_valid), '0);
    check(out_vec == '0, "R7", "out_vec in reset", out_vec, '0);
    in_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;

    // R4: zero shift
    send(ramp_vec(), 0, "R4");
    send(rand_vec(), 0, "R4");
    idle(2);

    // R1: every down shift, back to back
    for (int s = 0; s < P_LEN; s++) send(ramp_vec(), s, "R1");
    idle(1);

    // R5: wrap at the vector length near the end
    send(ramp_vec(), 60, "R5");
    send(ramp_vec(), 59, "R5");
    send(rand_vec(), 33, "R5");
    idle(1);

    // R2: every up shift
    for (int u = 1; u < P_LEN; u++) send(rand_vec(), -u, "R2");
    idle(1);

    // R3: magnitudes of P_LEN and beyond, extreme codes
    send(rand_vec(), 61, "R3");
    send(rand_vec(), -61, "R3");
    send(ramp_vec(), 64, "R3");
    send(ramp_vec(), 127, "R3");
    send(ramp_vec(), -128, "R3");
    send(rand_vec(), -122, "R3");
    send(rand_vec(), 122, "R3");
    idle(1);

    // R8: full bit patterns
    send(bits_vec(), 7, "R8");
    send(bits_vec(), -5, "R8");
    send(~bits_vec(), 1, "R8");
    idle(1);

    // R6: streaming with gaps
    for (int k = 0; k < 20; k++) begin
      rv = rand_vec();
      send(rv, int'($urandom_range(0, 200)) - 100, "R6");
      if (k % 4 == 3) idle(k % 3 + 1);
    end
    idle(3);

    check(exp_q.size() == 0, "R6", "scoreboard drained",
          VEC_W'(exp_q.size()), '0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule